// File: doc/BRIEF.md
# Dead-Beat Current Regulator with Line-Voltage Estimator

This block computes the converter voltage command for a three-phase voltage-source converter working as a rectifier or as a shunt active filter. All arithmetic runs in fixed point on the two stationary-frame axes (alpha and beta). On each accepted sample strobe the block takes the measured axis currents, a filtered line-voltage estimate, a distorting-load current term and a conductance-type gain. It then produces the voltage that brings the current onto its reference by the end of the following modulation period. The control is meant to run twice per modulation period, so reference tracking lags by no more than one period.

No line-voltage sensor is used. The block rebuilds the line voltage of the previous interval from the command it issued then and from the current change seen since. That raw estimate is an output. An external filter (out of scope) smooths it and returns it on the filtered-estimate inputs, which feed both the reference generation and the control law. One multiplier is shared by the three products on each axis. A fixed sequence of steps ends in a one-cycle done pulse.

Top module: `deadbeat_cc`

## Requirements
- R1: While rst_n is low and after its release, v_al, v_be, e_al, e_be, sat_al, sat_be and done are 0, and the stored previous command and previous current on both axes are 0.
- R2: A start seen while the block is idle is accepted and all inputs are captured at that edge. done is high for exactly one cycle, 7 rising edges after the accepting edge. A start seen during any of those 7 edges, including the edge that raises done, is ignored and yields no further done.
- R3: Per axis the reference is iref = clamp(i_ld + (mode_flt ? floor(g_ref*e_flt / 2^QF) : 0)). g_ref is signed two's complement with QF=8 fraction bits, and clamp limits to the symmetric range ±(2^(W-1)-1) = ±32767.
- R4: Per axis the unclipped command is v_raw = e_flt + floor(k_lt*(iref - i) / 2^QF), where k_lt (L over T) is signed with QF fraction bits.
- R5: Per axis the command output is v_raw clipped to the range ±v_lim, where v_lim is unsigned. The axis saturation flag is 1 exactly when clipping took place.
- R6: Per axis the raw estimate is e = clamp(vp - floor(k_lt*(i - ip) / 2^QF)), where vp is the clipped command and ip the current of the previously accepted sample (both 0 after reset), using the same ±32767 clamp.
- R7: v_al, v_be, e_al, e_be, sat_al and sat_be change only on the edge that raises done and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample strobe, accepted when idle |
| mode_flt | input | 1 | 1: estimate term active in the reference (filter mode); 0: rectifier mode |
| i_al | input | W | Measured alpha current, signed |
| i_be | input | W | Measured beta current, signed |
| e_flt_al | input | W | Filtered alpha line-voltage estimate, signed |
| e_flt_be | input | W | Filtered beta line-voltage estimate, signed |
| i_ld_al | input | W | Alpha distorting-load reference term, signed |
| i_ld_be | input | W | Beta distorting-load reference term, signed |
| g_ref | input | GW | Reference conductance gain, signed Q with QF fraction bits |
| k_lt | input | GW | Model inductance over period, signed Q with QF fraction bits |
| v_lim | input | W-1 | Command magnitude limit, unsigned |
| v_al | output | W | Alpha voltage command, signed |
| v_be | output | W | Beta voltage command, signed |
| e_al | output | W | Alpha raw line-voltage estimate, signed |
| e_be | output | W | Beta raw line-voltage estimate, signed |
| sat_al | output | 1 | Alpha command was clipped |
| sat_be | output | 1 | Beta command was clipped |
| done | output | 1 | One-cycle result strobe |

## Verification
The bound checker watches on every cycle the fixed start-to-done distance, the single-cycle done pulse, that results move only with done, that each command stays within the limit captured at its start, that a raised saturation flag always pairs with a command at that limit, and that the estimates never take the most negative code. Only the scenarios can show the arithmetic: the reference built with and without the estimate term, the dead-beat gain on the current error, the estimate's use of the previous sample's clipped command and current, the clamps at the reference and estimate edges, and the ignored strobes during and at the end of a computation.

// File: rtl/dbcc_pkg.sv
package dbcc_pkg;
   typedef enum logic [2:0] {
      ST_REF_A = 3'd0,
      ST_V_A   = 3'd1,
      ST_E_A   = 3'd2,
      ST_REF_B = 3'd3,
      ST_V_B   = 3'd4,
      ST_E_B   = 3'd5,
      ST_COMMIT = 3'd6,
      ST_IDLE  = 3'd7
   } dbcc_step_t;

   // rising edges from accepting start to the edge that raises done
   localparam int DBCC_LAT = 7;
endpackage

// File: rtl/dbcc_mul.sv
module dbcc_mul #(
   parameter int AW       = 18,
   parameter int BW       = 16,
   parameter int QF       = 8,
   parameter int ACC_W    = 36,
   parameter bit ROUND_EN = 1'b0
) (
   input  logic signed [AW-1:0]    a,
   input  logic signed [BW-1:0]    b,
   output logic signed [ACC_W-1:0] p
);
   localparam int PW = AW + BW;

   if (ACC_W < PW + 2) begin : g_bad_acc
      $error("dbcc_mul: ACC_W too small");
   end
   if (QF < 1) begin : g_bad_qf
      $error("dbcc_mul: QF must be at least 1");
   end

   logic signed [PW-1:0] full;
   logic signed [PW:0]   ext;
   logic signed [PW:0]   adj;
   logic signed [PW:0]   shr;

   assign full = a * b;
   assign ext  = {full[PW-1], full};

   if (ROUND_EN) begin : g_round
      assign adj = ext + (PW+1)'(1 << (QF-1));
   end else begin : g_floor
      assign adj = ext;
   end

   assign shr = adj >>> QF;
   assign p   = {{(ACC_W-PW-1){shr[PW]}}, shr};
endmodule

// File: rtl/dbcc_clamp.sv
module dbcc_clamp #(
   parameter int IN_W  = 36,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  x,
   input  logic        [OUT_W-2:0] lim,
   output logic signed [OUT_W-1:0] y,
   output logic                    clip
);
   if (IN_W <= OUT_W) begin : g_bad_w
      $error("dbcc_clamp: input must be wider than output");
   end

   logic signed [IN_W-1:0] hi;
   logic signed [IN_W-1:0] lo;

   assign hi = {{(IN_W-OUT_W+1){1'b0}}, lim};
   assign lo = -hi;

   always_comb begin
      clip = 1'b0;
      y    = x[OUT_W-1:0];
      if (x > hi) begin
         y    = hi[OUT_W-1:0];
         clip = 1'b1;
      end else if (x < lo) begin
         y    = lo[OUT_W-1:0];
         clip = 1'b1;
      end
   end
endmodule

// File: rtl/deadbeat_cc.sv
module deadbeat_cc #(
   parameter int W        = 16,
   parameter int GW       = 16,
   parameter int QF       = 8,
   parameter bit ROUND_EN = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                mode_flt,
   input  logic signed [W-1:0] i_al,
   input  logic signed [W-1:0] i_be,
   input  logic signed [W-1:0] e_flt_al,
   input  logic signed [W-1:0] e_flt_be,
   input  logic signed [W-1:0] i_ld_al,
   input  logic signed [W-1:0] i_ld_be,
   input  logic signed [GW-1:0] g_ref,
   input  logic signed [GW-1:0] k_lt,
   input  logic        [W-2:0] v_lim,
   output logic signed [W-1:0] v_al,
   output logic signed [W-1:0] v_be,
   output logic signed [W-1:0] e_al,
   output logic signed [W-1:0] e_be,
   output logic                sat_al,
   output logic                sat_be,
   output logic                done
);
   import dbcc_pkg::*;

   localparam int AW    = W + 2;
   localparam int ACC_W = AW + GW + 2;
   localparam int NAX   = 2;

   if (W < 4) begin : g_bad_w
      $error("deadbeat_cc: W must be at least 4");
   end
   if (QF < 1 || QF >= GW) begin : g_bad_qf
      $error("deadbeat_cc: QF must lie in 1..GW-1");
   end

   dbcc_step_t st;

   logic signed [W-1:0] i_q  [NAX];
   logic signed [W-1:0] ef_q [NAX];
   logic signed [W-1:0] il_q [NAX];
   logic signed [W-1:0] ip_q [NAX];
   logic signed [W-1:0] vp_q [NAX];
   logic signed [W-1:0] vw_q [NAX];
   logic signed [W-1:0] ew_q [NAX];
   logic                sw_q [NAX];
   logic signed [W-1:0] iref_q;
   logic                mode_q;
   logic signed [GW-1:0] g_q;
   logic signed [GW-1:0] k_q;
   logic        [W-2:0]  lim_q;

   logic                 ax;
   logic signed [W-1:0]  cur_i, cur_ip, cur_ef, cur_il, cur_vp;
   logic signed [AW-1:0] mul_a;
   logic signed [GW-1:0] mul_b;
   logic signed [ACC_W-1:0] prod;
   logic signed [ACC_W-1:0] v_sum;
   logic signed [ACC_W-1:0] g_sum;
   logic signed [W-1:0]  v_y, g_y;
   logic                 v_clip, g_clip;

   assign ax = (st == ST_REF_B) || (st == ST_V_B) || (st == ST_E_B);

   always_comb begin
      cur_i  = i_q[ax];
      cur_ip = ip_q[ax];
      cur_ef = ef_q[ax];
      cur_il = il_q[ax];
      cur_vp = vp_q[ax];
      mul_a  = '0;
      mul_b  = k_q;
      unique case (st)
         ST_REF_A, ST_REF_B: begin
            mul_a = {{2{cur_ef[W-1]}}, cur_ef};
            mul_b = g_q;
         end
         ST_V_A, ST_V_B:
            mul_a = {{2{iref_q[W-1]}}, iref_q} - {{2{cur_i[W-1]}}, cur_i};
         ST_E_A, ST_E_B:
            mul_a = {{2{cur_i[W-1]}}, cur_i} - {{2{cur_ip[W-1]}}, cur_ip};
         default: mul_a = '0;
      endcase
   end

   dbcc_mul #(
      .AW(AW), .BW(GW), .QF(QF), .ACC_W(ACC_W), .ROUND_EN(ROUND_EN)
   ) u_mul (
      .a(mul_a), .b(mul_b), .p(prod)
   );

   always_comb begin
      v_sum = {{(ACC_W-W){cur_ef[W-1]}}, cur_ef} + prod;
      if ((st == ST_E_A) || (st == ST_E_B))
         g_sum = {{(ACC_W-W){cur_vp[W-1]}}, cur_vp} - prod;
      else if (mode_q)
         g_sum = {{(ACC_W-W){cur_il[W-1]}}, cur_il} + prod;
      else
         g_sum = {{(ACC_W-W){cur_il[W-1]}}, cur_il};
   end

   dbcc_clamp #(.IN_W(ACC_W), .OUT_W(W)) u_clamp_v (
      .x(v_sum), .lim(lim_q), .y(v_y), .clip(v_clip)
   );

   dbcc_clamp #(.IN_W(ACC_W), .OUT_W(W)) u_clamp_g (
      .x(g_sum), .lim({(W-1){1'b1}}), .y(g_y), .clip(g_clip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         done   <= 1'b0;
         v_al   <= '0;
         v_be   <= '0;
         e_al   <= '0;
         e_be   <= '0;
         sat_al <= 1'b0;
         sat_be <= 1'b0;
         iref_q <= '0;
         mode_q <= 1'b0;
         g_q    <= '0;
         k_q    <= '0;
         lim_q  <= '0;
         for (int n = 0; n < NAX; n++) begin
            i_q[n]  <= '0;
            ef_q[n] <= '0;
            il_q[n] <= '0;
            ip_q[n] <= '0;
            vp_q[n] <= '0;
            vw_q[n] <= '0;
            ew_q[n] <= '0;
            sw_q[n] <= 1'b0;
         end
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (start) begin
               i_q[0]  <= i_al;     i_q[1]  <= i_be;
               ef_q[0] <= e_flt_al; ef_q[1] <= e_flt_be;
               il_q[0] <= i_ld_al;  il_q[1] <= i_ld_be;
               mode_q  <= mode_flt;
               g_q     <= g_ref;
               k_q     <= k_lt;
               lim_q   <= v_lim;
               st      <= ST_REF_A;
            end
            ST_REF_A, ST_REF_B: begin
               iref_q <= g_y;
               st     <= (st == ST_REF_A) ? ST_V_A : ST_V_B;
            end
            ST_V_A, ST_V_B: begin
               vw_q[ax] <= v_y;
               sw_q[ax] <= v_clip;
               st       <= (st == ST_V_A) ? ST_E_A : ST_E_B;
            end
            ST_E_A, ST_E_B: begin
               ew_q[ax] <= g_y;
               st       <= (st == ST_E_A) ? ST_REF_B : ST_COMMIT;
            end
            ST_COMMIT: begin
               v_al   <= vw_q[0];
               v_be   <= vw_q[1];
               e_al   <= ew_q[0];
               e_be   <= ew_q[1];
               sat_al <= sw_q[0];
               sat_be <= sw_q[1];
               for (int n = 0; n < NAX; n++) begin
                  vp_q[n] <= vw_q[n];
                  ip_q[n] <= i_q[n];
               end
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbcc_chk.sv
module dbcc_chk #(
   parameter int W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                done,
   input logic        [W-2:0] v_lim,
   input logic signed [W-1:0] v_al,
   input logic signed [W-1:0] v_be,
   input logic signed [W-1:0] e_al,
   input logic signed [W-1:0] e_be,
   input logic                sat_al,
   input logic                sat_be
);
   import dbcc_pkg::*;

   localparam int CW = $clog2(DBCC_LAT + 1) + 1;
   localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

   logic [CW-1:0] cnt;
   logic [W-2:0]  lim_c;

   function automatic logic [W-1:0] mag(input logic signed [W-1:0] x);
      return x[W-1] ? W'(-x) : W'(x);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         lim_c <= '0;
      end else if (cnt == '0) begin
         if (start) begin
            cnt   <= CW'(1);
            lim_c <= v_lim;
         end
      end else if (cnt == CW'(DBCC_LAT)) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   AST_DONE_AFTER_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(DBCC_LAT)) |=> done); // R2
   AST_DONE_ONLY_AT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(cnt == CW'(DBCC_LAT))); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R2
   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(v_al) && $stable(v_be) && $stable(e_al) && $stable(e_be)
                 && $stable(sat_al) && $stable(sat_be))); // R7
   AST_V_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (mag(v_al) <= {1'b0, lim_c} && mag(v_be) <= {1'b0, lim_c})); // R5
   AST_SAT_AT_LIMIT_A: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sat_al) |-> (mag(v_al) == {1'b0, lim_c})); // R5
   AST_SAT_AT_LIMIT_B: assert property (@(posedge clk) disable iff (!rst_n)
      (done && sat_be) |-> (mag(v_be) == {1'b0, lim_c})); // R5
   AST_EST_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
      (e_al != MOST_NEG) && (e_be != MOST_NEG)); // R6
endmodule

bind deadbeat_cc dbcc_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .done(done), .v_lim(v_lim),
   .v_al(v_al), .v_be(v_be), .e_al(e_al), .e_be(e_be),
   .sat_al(sat_al), .sat_be(sat_be)
);

// File: tb/tb_deadbeat_cc.sv
module tb_deadbeat_cc;
   localparam int  W    = 16;
   localparam int  GW   = 16;
   localparam int  QF   = 8;
   localparam int  LAT  = 7;
   localparam longint MAXV = 32767;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic mode_flt = 1'b0;
   logic signed [W-1:0] i_al = '0, i_be = '0, e_flt_al = '0, e_flt_be = '0;
   logic signed [W-1:0] i_ld_al = '0, i_ld_be = '0;
   logic signed [GW-1:0] g_ref = '0, k_lt = '0;
   logic [W-2:0] v_lim = '0;
   logic signed [W-1:0] v_al, v_be, e_al, e_be;
   logic sat_al, sat_be, done;

   always #5 clk = ~clk;

   deadbeat_cc dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_flt(mode_flt),
      .i_al(i_al), .i_be(i_be), .e_flt_al(e_flt_al), .e_flt_be(e_flt_be),
      .i_ld_al(i_ld_al), .i_ld_be(i_ld_be), .g_ref(g_ref), .k_lt(k_lt),
      .v_lim(v_lim), .v_al(v_al), .v_be(v_be), .e_al(e_al), .e_be(e_be),
      .sat_al(sat_al), .sat_be(sat_be), .done(done)
   );

   typedef struct {
      longint v0, v1, e0, e1;
      bit     s0, s1;
      string  tag;
   } exp_t;

   exp_t   sb[$];
   int     n_chk = 0;
   int     n_fail = 0;
   int     n_done = 0;
   int     n_push = 0;
   longint mvp [2];
   longint mip [2];
   exp_t   last;

   function automatic longint clampv(input longint x, input longint lim);
      if (x > lim) return lim;
      if (x < -lim) return -lim;
      return x;
   endfunction

   function automatic longint qmul(input longint a, input longint b);
      return (a * b) >>> QF;
   endfunction

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // monitor: pop scoreboard on every done pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_done++;
         if (sb.size() == 0) begin
            check("R2", "unexpected done", 1, 0);
         end else begin
            exp_t x;
            x = sb.pop_front();
            check("R4/R5", {x.tag, " v_al"}, longint'(v_al), x.v0);
            check("R4/R5", {x.tag, " v_be"}, longint'(v_be), x.v1);
            check("R6", {x.tag, " e_al"}, longint'(e_al), x.e0);
            check("R6", {x.tag, " e_be"}, longint'(e_be), x.e1);
            check("R5", {x.tag, " sat_al"}, longint'(sat_al), longint'(x.s0));
            check("R5", {x.tag, " sat_be"}, longint'(sat_be), longint'(x.s1));
            last = x;
         end
      end
   end

   // driver: compute expectation from R3..R6, push it, then strobe start
   task automatic drive(input string tag, input bit m,
                        input longint ia, input longint ib,
                        input longint efa, input longint efb,
                        input longint ila, input longint ilb,
                        input longint g, input longint k, input longint lim,
                        input bit junk_mid, input bit junk_end);
      longint ci [2];
      longint ce [2];
      longint cl [2];
      longint vr, ir;
      exp_t   x;
      int     n;
      ci[0] = ia;  ci[1] = ib;
      ce[0] = efa; ce[1] = efb;
      cl[0] = ila; cl[1] = ilb;
      x.tag = tag;
      for (int a = 0; a < 2; a++) begin
         longint vv, ee;
         bit     ss;
         ir = clampv(cl[a] + (m ? qmul(g, ce[a]) : 0), MAXV);        // R3
         vr = ce[a] + qmul(k, ir - ci[a]);                           // R4
         vv = clampv(vr, lim);                                       // R5
         ss = (vv != vr);
         ee = clampv(mvp[a] - qmul(k, ci[a] - mip[a]), MAXV);        // R6
         mvp[a] = vv;
         mip[a] = ci[a];
         if (a == 0) begin x.v0 = vv; x.e0 = ee; x.s0 = ss; end
         else        begin x.v1 = vv; x.e1 = ee; x.s1 = ss; end
      end
      sb.push_back(x);
      n_push++;
      mode_flt = m;
      i_al = W'(ia); i_be = W'(ib);
      e_flt_al = W'(efa); e_flt_be = W'(efb);
      i_ld_al = W'(ila); i_ld_be = W'(ilb);
      g_ref = GW'(g); k_lt = GW'(k); v_lim = (W-1)'(lim);
      start = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         start = 1'b0;
         if (n == 1) begin
            // captured inputs must not matter once the start was taken (R2)
            i_al = 16'sd1234; e_flt_be = -16'sd777; k_lt = 16'sd5;
         end
         if (junk_mid && n == 3) start = 1'b1;   // busy: ignored (R2)
         if (junk_end && n == 7) start = 1'b1;   // sampled on the done edge: ignored (R2)
      end while (!done && n < 40);
      // start strobed at negedge N0; done visible at N8, i.e. LAT+1 negedges later (R2)
      check("R2", {tag, " latency"}, n, LAT + 1);
      repeat (3) @(negedge clk);
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mvp[0] = 0; mvp[1] = 0; mip[0] = 0; mip[1] = 0;
      @(negedge clk);
   endtask

   task automatic check_reset_state(input string tag);
      check("R1", {tag, " v_al"}, longint'(v_al), 0);
      check("R1", {tag, " v_be"}, longint'(v_be), 0);
      check("R1", {tag, " e_al"}, longint'(e_al), 0);
      check("R1", {tag, " e_be"}, longint'(e_be), 0);
      check("R1", {tag, " sat"}, longint'({sat_al, sat_be}), 0);
      check("R1", {tag, " done"}, longint'(done), 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog expired: actual hung expected finished");
      finish_run();
   end

   initial begin
      mvp[0] = 0; mvp[1] = 0; mip[0] = 0; mip[1] = 0;
      apply_reset();
      check_reset_state("R1 after reset");

      // R3 rectifier mode: estimate term absent; first estimate uses zero history (R6)
      drive("R3 rect", 1'b0, 100, -50, 1000, -500, 200, 300, 64, 384, 20000, 1'b0, 1'b0);
      // R3 filter mode: reference includes g*e_flt; estimate uses previous sample (R6)
      drive("R3 filt", 1'b1, 150, -20, 1200, -900, -100, 50, 64, 384, 20000, 1'b0, 1'b0);
      // R4 negative gains and signs, floor of negative products
      drive("R4 neg", 1'b1, -333, 777, -2001, 1501, 17, -19, -45, 301, 30000, 1'b0, 1'b0);
      // R5 clipping in both directions, small limit
      drive("R5 sat", 1'b0, -8000, 8000, 0, 0, 8000, -8000, 64, 384, 5000, 1'b0, 1'b0);
      // R5 exactly at limit is not a clip: iref=i, v=e_flt=5000
      drive("R5 edge", 1'b0, 40, 40, 5000, -5000, 40, 40, 0, 256, 5000, 1'b0, 1'b0);
      // R3 reference clamp at +-32767 with large gain
      drive("R3 clamp", 1'b1, 0, 0, 10000, -10000, 0, 0, 32767, 1, 32767, 1'b0, 1'b0);
      // R6 estimate clamp with a large current jump
      drive("R6 clamp", 1'b0, -30000, 30000, 0, 0, 0, 0, 0, 32767, 100, 1'b0, 1'b0);
      // R2 strobes during the computation and on the done edge are ignored
      drive("R2 busy", 1'b1, 10, 20, 300, 400, 5, 6, 128, 200, 20000, 1'b1, 1'b1);
      repeat (20) @(negedge clk);
      check("R2", "done count equals accepted starts", n_done, n_push);

      // R7 outputs hold long after done
      repeat (15) @(negedge clk);
      check("R7", "v_al held", longint'(v_al), last.v0);
      check("R7", "e_be held", longint'(e_be), last.e1);

      // R1 reset clears outputs and history
      apply_reset();
      check_reset_state("R1 second reset");
      drive("R1 history cleared", 1'b0, 500, -500, 0, 0, 0, 0, 0, 256, 20000, 1'b0, 1'b0);
      repeat (5) @(negedge clk);
      check("R2", "scoreboard drained", sb.size(), 0);
      finish_run();
   end
endmodule